// File: doc/BRIEF.md
# Three-Button Sequence Lock

This block is a small Mealy state machine that guards a door. It watches three push buttons and raises its solenoid output once the buttons are pressed in the order 3, 2, 1. An upstream stage supplies one button sample per clock cycle, already converted from presses into pulses. Each sample is either all zero (no press) or has exactly one bit set. Any sample with more than one bit set is illegal and abandons the partial sequence.

The machine keeps its progress in a two-bit state register with three legal codes. The next-state logic and the unlock decode both read the current button sample. The unlock is therefore raised in the same cycle as the closing press, and it does not wait for a state update. The button and solenoid pins are plain control signals sampled and driven each cycle, so there is no handshake and no back-pressure. The solenoid driver and the debouncing of the buttons sit outside the block.

Top module: `lock_seq_top`

## Requirements
- R1: A synchronous active-high reset puts the machine in the initial state (code 00), and the solenoid output stays low in every cycle in which reset is high.
- R2: The button vector maps bit 0 to button 1, bit 1 to button 2 and bit 2 to button 3, and 000 means no press. In the initial state, button 3 advances to the first-ok state (code 01). Button 1, button 2 and no press leave the machine in the initial state.
- R3: In the first-ok state, no press and button 3 both keep the state. Button 2 advances to the second-ok state (code 10), and button 1 returns to the initial state.
- R4: In the second-ok state, no press keeps the state, and any single press (button 1, 2 or 3) returns to the initial state.
- R5: The solenoid output is high in exactly those cycles where the state is second-ok and the input is 001. It changes in the same cycle as the input, with no register delay.
- R6: An unlock is a one-cycle pulse. Holding button 1 in the cycles after an unlock gives no further pulse.
- R7: Any input with two or more bits set sends the machine to the initial state, and the solenoid stays low in that cycle. This holds even when bit 0 is among the set bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| btn_i | input | BTN_W (3) | Button sample: bit 2 = button 3, bit 1 = button 2, bit 0 = button 1 |
| solenoid_o | output | 1 | Unlock pulse (Mealy) |

## Verification
The bench builds the block with its default width of three buttons. That width covers every legal one-hot sample and every two- and three-bit illegal pattern: 011, 101, 110 and 111. With it the bench can hold each state with idle cycles and step through repeated first digits. It also exercises every exit from the second-ok state, including the illegal 101 case, where bit 0 must not unlock. Since only the solenoid is visible, each sequence ends in a probe that shows where the machine stands: a run that should have reset stays locked, and a legal run completes with exactly one pulse.

// File: rtl/lock_pkg.sv
`timescale 1ns/1ps
package lock_pkg;
  localparam int NUM_BTN    = 3;
  // bit position of each button in the input vector
  localparam int KEY_FIRST  = 2;  // button 3
  localparam int KEY_SECOND = 1;  // button 2
  localparam int KEY_LAST   = 0;  // button 1

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_GOT3  = 2'b01,
    ST_GOT32 = 2'b10,
    ST_BAD   = 2'b11
  } lock_state_t;
endpackage

// File: rtl/lock_btn_decode.sv
`timescale 1ns/1ps
module lock_btn_decode #(
  parameter int BTN_W = lock_pkg::NUM_BTN
) (
  input  logic [BTN_W-1:0] btn_i,
  output logic [BTN_W-1:0] single_o,
  output logic             none_o,
  output logic             multi_o
);
  localparam logic [BTN_W-1:0] ONE = {{(BTN_W-1){1'b0}}, 1'b1};

  // single_o[i]: bit i set and no other bit set
  for (genvar i = 0; i < BTN_W; i++) begin : g_single
    assign single_o[i] = btn_i[i] && ((btn_i & ~(ONE << i)) == '0);
  end

  assign none_o  = (btn_i == '0);
  assign multi_o = !none_o && (single_o == '0);
endmodule

// File: rtl/lock_next_state.sv
`timescale 1ns/1ps
module lock_next_state #(
  parameter int BTN_W = lock_pkg::NUM_BTN
) (
  input  lock_pkg::lock_state_t state_i,
  input  logic [BTN_W-1:0]      single_i,
  input  logic                  none_i,
  input  logic                  multi_i,
  output lock_pkg::lock_state_t next_o
);
  import lock_pkg::*;

  always_comb begin
    next_o = ST_IDLE;
    if (!multi_i) begin
      unique case (state_i)
        ST_IDLE:  next_o = single_i[KEY_FIRST] ? ST_GOT3 : ST_IDLE;
        ST_GOT3: begin
          if (none_i || single_i[KEY_FIRST]) next_o = ST_GOT3;
          else if (single_i[KEY_SECOND])     next_o = ST_GOT32;
          else                               next_o = ST_IDLE;
        end
        ST_GOT32: next_o = none_i ? ST_GOT32 : ST_IDLE;
        default:  next_o = ST_IDLE;  // unused code recovers
      endcase
    end
  end
endmodule

// File: rtl/lock_state_reg.sv
`timescale 1ns/1ps
module lock_state_reg (
  input  logic                  clk_i,
  input  logic                  rst_i,
  input  lock_pkg::lock_state_t next_i,
  output lock_pkg::lock_state_t state_o
);
  always_ff @(posedge clk_i) begin
    if (rst_i) state_o <= lock_pkg::ST_IDLE;
    else       state_o <= next_i;
  end
endmodule

// File: rtl/lock_seq_top.sv
`timescale 1ns/1ps
module lock_seq_top #(
  parameter int BTN_W = lock_pkg::NUM_BTN
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [BTN_W-1:0] btn_i,
  output logic             solenoid_o
);
  import lock_pkg::*;

  logic [BTN_W-1:0] single;
  logic             none;
  logic             multi;
  lock_state_t      state_q;
  lock_state_t      state_d;

  lock_btn_decode #(.BTN_W(BTN_W)) u_dec (
    .btn_i    (btn_i),
    .single_o (single),
    .none_o   (none),
    .multi_o  (multi)
  );

  lock_next_state #(.BTN_W(BTN_W)) u_nxt (
    .state_i  (state_q),
    .single_i (single),
    .none_i   (none),
    .multi_i  (multi),
    .next_o   (state_d)
  );

  lock_state_reg u_reg (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .next_i  (state_d),
    .state_o (state_q)
  );

  // Mealy unlock: final press while in second-ok
  assign solenoid_o = !rst_i && (state_q == ST_GOT32) && single[KEY_LAST];
endmodule

// File: rtl/lock_seq_checker.sv
`timescale 1ns/1ps
module lock_seq_checker #(
  parameter int BTN_W = 3
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic [BTN_W-1:0] btn_i,
  input logic             solenoid_o,
  input logic [1:0]       state_q
);
  localparam logic [BTN_W-1:0] B3 = BTN_W'(4);
  localparam logic [BTN_W-1:0] B2 = BTN_W'(2);

  always_comb begin
    if (rst_i) begin
      a_r1_quiet_in_reset: assert (!solenoid_o);
    end
  end

  a_r1_reset_to_idle: assert property (@(posedge clk_i) disable iff (rst_i)
    $past(rst_i) |-> state_q == 2'b00);

  a_r2_idle_waits_for_three: assert property (@(posedge clk_i) disable iff (rst_i)
    (state_q == 2'b00 && btn_i != B3) |=> state_q == 2'b00);

  a_r3_two_advances: assert property (@(posedge clk_i) disable iff (rst_i)
    (state_q == 2'b01 && btn_i == B2) |=> state_q == 2'b10);

  a_r4_press_leaves_second: assert property (@(posedge clk_i) disable iff (rst_i)
    (state_q == 2'b10 && btn_i != '0) |=> state_q == 2'b00);

  a_r6_single_pulse: assert property (@(posedge clk_i) disable iff (rst_i)
    solenoid_o |=> !solenoid_o);

  a_r7_illegal_clears: assert property (@(posedge clk_i) disable iff (rst_i)
    ($countones(btn_i) > 1) |=> state_q == 2'b00);

  a_r7_illegal_no_unlock: assert property (@(posedge clk_i) disable iff (rst_i)
    ($countones(btn_i) > 1) |-> !solenoid_o);
endmodule

bind lock_seq_top lock_seq_checker #(.BTN_W(BTN_W)) u_chk (
  .clk_i      (clk_i),
  .rst_i      (rst_i),
  .btn_i      (btn_i),
  .solenoid_o (solenoid_o),
  .state_q    (state_q)
);

// File: tb/lock_seq_top_tb.sv
`timescale 1ns/1ps
module lock_seq_top_tb;
  localparam int BTN_W = 3;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [BTN_W-1:0] btn = '0;
  logic             solenoid;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  logic  exp_q[$];
  string tag_q[$];

  lock_seq_top #(.BTN_W(BTN_W)) u_dut (
    .clk_i      (clk),
    .rst_i      (rst),
    .btn_i      (btn),
    .solenoid_o (solenoid)
  );

  always #10 clk = ~clk;  // 50 MHz

  // driver: one input sample per cycle, expected output queued
  task automatic step(input logic r, input logic [BTN_W-1:0] b, input logic e, input string tag);
    @(posedge clk);
    #2;
    rst = r;
    btn = b;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  // monitor: the Mealy output is valid mid-cycle
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic  e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_tests++;
      if (solenoid !== e) begin
        n_fail++;
        $display("FAIL %s: solenoid actual %b expected %b", t, solenoid, e);
      end
    end
  end

  initial begin
    // R1: reset holds output low even with button 1 pressed
    step(1, 3'b001, 0, "R1 reset");
    step(1, 3'b001, 0, "R1 reset");
    step(0, 3'b001, 0, "R1 idle after reset");
    // R5 basic unlock
    step(0, 3'b100, 0, "R2 press 3");
    step(0, 3'b010, 0, "R3 press 2");
    step(0, 3'b001, 1, "R5 unlock");
    // R2/R3/R4 idle cycles hold state
    step(0, 3'b000, 0, "R2 idle");
    step(0, 3'b100, 0, "R2 press 3");
    step(0, 3'b000, 0, "R3 hold");
    step(0, 3'b000, 0, "R3 hold");
    step(0, 3'b010, 0, "R3 press 2");
    step(0, 3'b000, 0, "R4 hold");
    step(0, 3'b000, 0, "R4 hold");
    step(0, 3'b001, 1, "R4 unlock after holds");
    // R3 repeated first digit keeps progress
    step(0, 3'b100, 0, "R3 press 3");
    step(0, 3'b100, 0, "R3 repeat 3");
    step(0, 3'b100, 0, "R3 repeat 3");
    step(0, 3'b010, 0, "R3 press 2");
    step(0, 3'b001, 1, "R3 unlock after repeats");
    // R2 buttons 2 and 1 ignored in initial state
    step(0, 3'b010, 0, "R2 press 2 in idle");
    step(0, 3'b001, 0, "R2 press 1 in idle");
    step(0, 3'b100, 0, "R2 press 3");
    step(0, 3'b010, 0, "R2 press 2");
    step(0, 3'b001, 1, "R2 unlock");
    // R3 interrupted by wrong button
    step(0, 3'b100, 0, "R3 press 3");
    step(0, 3'b001, 0, "R3 wrong button 1");
    step(0, 3'b010, 0, "R3 press 2 after reset to idle");
    step(0, 3'b001, 0, "R3 interrupted no unlock");
    // R4 press 2 in second-ok returns to idle
    step(0, 3'b100, 0, "R4 press 3");
    step(0, 3'b010, 0, "R4 press 2");
    step(0, 3'b010, 0, "R4 second press 2");
    step(0, 3'b001, 0, "R4 no unlock after 2");
    // R4 press 3 in second-ok returns to idle, not first-ok
    step(0, 3'b100, 0, "R4 press 3");
    step(0, 3'b010, 0, "R4 press 2");
    step(0, 3'b100, 0, "R4 press 3 from second");
    step(0, 3'b010, 0, "R4 press 2 in idle");
    step(0, 3'b001, 0, "R4 no unlock after 3");
    // R6 single-cycle pulse
    step(0, 3'b100, 0, "R6 press 3");
    step(0, 3'b010, 0, "R6 press 2");
    step(0, 3'b001, 1, "R6 unlock");
    step(0, 3'b001, 0, "R6 held 1");
    step(0, 3'b001, 0, "R6 held 1");
    // R7 illegal inputs
    step(0, 3'b100, 0, "R7 press 3");
    step(0, 3'b110, 0, "R7 illegal 110");
    step(0, 3'b010, 0, "R7 press 2 after illegal");
    step(0, 3'b001, 0, "R7 no unlock");
    step(0, 3'b100, 0, "R7 press 3");
    step(0, 3'b010, 0, "R7 press 2");
    step(0, 3'b101, 0, "R7 illegal 101 in second-ok");
    step(0, 3'b001, 0, "R7 no unlock after 101");
    step(0, 3'b100, 0, "R7 press 3");
    step(0, 3'b010, 0, "R7 press 2");
    step(0, 3'b011, 0, "R7 illegal 011 in second-ok");
    step(0, 3'b001, 0, "R7 no unlock after 011");
    step(0, 3'b111, 0, "R7 illegal 111");
    step(0, 3'b100, 0, "R7 press 3");
    step(0, 3'b010, 0, "R7 press 2");
    step(0, 3'b001, 1, "R7 unlock recovers");
    // R1 reset mid sequence
    step(0, 3'b100, 0, "R1 press 3");
    step(0, 3'b010, 0, "R1 press 2");
    step(1, 3'b001, 0, "R1 reset with 1");
    step(0, 3'b001, 0, "R1 no unlock after reset");
    step(0, 3'b000, 0, "R1 idle");
    @(posedge clk);
    @(posedge clk);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule